// File: doc/BRIEF.md
# Multiplexed Bus Cycle Controller

This block runs one read or write machine cycle at a time on an external bus. The low byte of the address and the data byte share the same eight lines, and the upper address byte has lines of its own. A requester hands over an address, write data, a read/write choice and a memory/I/O choice. The block sequences the cycle. It pulses an address-latch strobe while the shared lines carry the low address, drives an active-low read or write strobe, and stretches the strobe by whole clocks while the slave holds `ready` low. A read ends with the captured byte on `rd_data` and a one-clock `done` pulse. Between cycles the block may hand the bus to another master. On `hold` it releases every bus line and raises `hlda`.

The controller is a six-state machine:

- `ST_IDLE`: no cycle.
- `ST_T1`: address phase with the latch strobe.
- `ST_T2`: strobe asserted, `ready` sampled.
- `ST_TW`: wait state.
- `ST_T3`: strobe released, transfer completes.
- `ST_HOLD`: bus released.

The transitions are:

- IDLE→HOLD when `hold` is high. This takes priority over a request.
- IDLE→T1 on a request.
- T1→T2 always.
- T2→T3 when `ready` is high, and T2→TW when it is low.
- TW stays in TW while `ready` is low, and goes TW→T3 when it is high.
- T3→IDLE always.
- HOLD→IDLE when `hold` is low.

Top module: `mbus_cycle_ctrl`

## Requirements
- R1: `ale` is high for exactly one clock, the T1 state, at the start of each cycle. While it is high, `ad_oe` is high and `ad_out` carries request address bits [7:0]. `a_hi` carries address bits [15:8] with `a_hi_oe` high from T1 through T3.
- R2: `io_m` is 1 for an I/O cycle and 0 for a memory cycle. It holds that value from T1 through T3.
- R3: Both strobes are active low. On a read only `rd_n` is asserted, and on a write only `wr_n` is asserted. A strobe is asserted in T2 and in every wait state, and is released (high) in T3. The two strobes are never low together.
- R4: While `ready` is low at a clock edge in T2 or a wait state, one more wait state follows. The strobe stays low for 1 + N clocks, where N is the number of such edges.
- R5: On a write, the shared lines are driven (`ad_oe` high) with the write data from T2 through the end of T3.
- R6: On a read, `ad_oe` is low after T1. `rd_data` takes the value on `ad_in` at the clock edge where `rd_n` returns high. `done` is high for exactly one clock, in T3, for both reads and writes.
- R7: `hold` is acted on only between cycles, so a cycle in progress completes first. While `hlda` is high, `ad_oe`, `a_hi_oe` and `ctl_oe` are low, both strobes are high and `ale` is low.
- R8: When `hold` is low at a clock edge while `hlda` is high, `hlda` falls after that edge. It is still high in the half clock before that edge.
- R9: While `rst_n` is low, all output enables are low, `reset_out` is high, the strobes are high and `hlda` is low. `reset_out` falls after the first clock edge with `rst_n` high.
- R10: `req_ready` is high only in IDLE with `hold` low. A `req_valid` seen at any other time starts no cycle (no `ale`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_ready | output | 1 | Request accepted this clock |
| ready | input | 1 | Slave ready; low inserts wait states |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus granted to the other master |
| ad_in | input | 8 | Shared lines as seen from the pins |
| ad_out | output | 8 | Shared lines driven value |
| ad_oe | output | 1 | Shared lines output enable |
| a_hi | output | 8 | Upper address lines |
| a_hi_oe | output | 1 | Upper address output enable |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | 1 = I/O cycle, 0 = memory cycle |
| ctl_oe | output | 1 | Strobe and status output enable |
| reset_out | output | 1 | Reset indication for other devices |
| rd_data | output | 8 | Byte captured by the last read |
| done | output | 1 | One-clock end-of-cycle pulse |

## Verification
The bench builds the block with its defaults: a 16-bit address and 8 shared lines. With these values the latched low byte and the upper byte together form the full address, which the bench compares against each request. Wait counts of 0 to 3 are driven through `ready`, which covers the T2→T3 path, the T2→TW path, the TW self-loop and the TW→T3 path. A hold raised in the middle of a read, together with a held-off request, exercises the between-cycles grant and the one-clock release.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_T3,
        ST_HOLD
    } bus_state_e;
endpackage

// File: rtl/mbus_seq_fsm.sv
module mbus_seq_fsm
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic              ready,
    input  logic              hold,
    output bus_state_e        state,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              write_q,
    output logic              io_q
);
    bus_state_e nxt;
    logic       accept;

    assign accept = (state == ST_IDLE) && !hold && req_valid;

    // State register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            io_q    <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                io_q    <= req_io;
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hold)           nxt = ST_HOLD;
                else if (req_valid) nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ready ? ST_T3 : ST_TW;
            ST_TW:   nxt = ready ? ST_T3 : ST_TW;
            ST_T3:   nxt = ST_IDLE;
            ST_HOLD: nxt = hold ? ST_HOLD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/mbus_pin_drv.sv
module mbus_pin_drv
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              rst_n,
    input  logic              hold,
    input  bus_state_e        state,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              write_q,
    input  logic              io_q,
    output logic              req_ready,
    output logic              ale,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              a_hi_oe,
    output logic              rd_n,
    output logic              wr_n,
    output logic              io_m,
    output logic              ctl_oe,
    output logic              hlda,
    output logic              done
);
    localparam int HI_W = ADDR_W - DATA_W;

    // Output decode
    always_comb begin
        req_ready = 1'b0;
        ale       = 1'b0;
        ad_out    = '0;
        ad_oe     = 1'b0;
        a_hi      = addr_q[ADDR_W-1 -: HI_W];
        a_hi_oe   = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        io_m      = 1'b0;
        ctl_oe    = rst_n;
        hlda      = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = !hold;
            ST_T1: begin
                ale     = 1'b1;
                ad_out  = addr_q[DATA_W-1:0];
                ad_oe   = 1'b1;
                a_hi_oe = 1'b1;
                io_m    = io_q;
            end
            ST_T2, ST_TW: begin
                ad_out  = wdata_q;
                ad_oe   = write_q;
                a_hi_oe = 1'b1;
                rd_n    = write_q;
                wr_n    = !write_q;
                io_m    = io_q;
            end
            ST_T3: begin
                ad_out  = wdata_q;
                ad_oe   = write_q;
                a_hi_oe = 1'b1;
                io_m    = io_q;
                done    = 1'b1;
            end
            ST_HOLD: begin
                hlda   = 1'b1;
                ctl_oe = 1'b0;
            end
            default: ;
        endcase
        if (!rst_n) begin
            req_ready = 1'b0;
            ale       = 1'b0;
            ad_oe     = 1'b0;
            a_hi_oe   = 1'b0;
            rd_n      = 1'b1;
            wr_n      = 1'b1;
            hlda      = 1'b0;
            done      = 1'b0;
        end
    end
endmodule

// File: rtl/mbus_rd_cap.sv
module mbus_rd_cap
    import mbus_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic              write_q,
    input  logic              ready,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] rd_data
);
    logic strobe_ends;

    // The read strobe rises on the edge that leaves T2/TW with ready high
    assign strobe_ends = ((state == ST_T2) || (state == ST_TW)) && ready && !write_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           rd_data <= '0;
        else if (strobe_ends) rd_data <= ad_in;
    end
endmodule

// File: rtl/mbus_cycle_ctrl.sv
module mbus_cycle_ctrl
    import mbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_write,
    input  logic                     req_io,
    output logic                     req_ready,
    input  logic                     ready,
    input  logic                     hold,
    output logic                     hlda,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     a_hi_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     io_m,
    output logic                     ctl_oe,
    output logic                     reset_out,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     done
);
    bus_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic              io_q;
    logic              rst_seen_q;

    mbus_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .ready(ready), .hold(hold), .state(state), .addr_q(addr_q),
        .wdata_q(wdata_q), .write_q(write_q), .io_q(io_q)
    );

    mbus_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
        .rst_n(rst_n), .hold(hold), .state(state), .addr_q(addr_q),
        .wdata_q(wdata_q), .write_q(write_q), .io_q(io_q),
        .req_ready(req_ready), .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe),
        .a_hi(a_hi), .a_hi_oe(a_hi_oe), .rd_n(rd_n), .wr_n(wr_n),
        .io_m(io_m), .ctl_oe(ctl_oe), .hlda(hlda), .done(done)
    );

    mbus_rd_cap #(.DATA_W(DATA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .state(state), .write_q(write_q),
        .ready(ready), .ad_in(ad_in), .rd_data(rd_data)
    );

    // Reset indication: high during reset, cleared by the first edge after it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_seen_q <= 1'b1;
        else        rst_seen_q <= 1'b0;
    end
    assign reset_out = rst_seen_q | !rst_n;
endmodule

// File: rtl/mbus_cycle_chk.sv
module mbus_cycle_chk (
    input logic clk,
    input logic rst_n,
    input logic ale,
    input logic ad_oe,
    input logic a_hi_oe,
    input logic ctl_oe,
    input logic rd_n,
    input logic wr_n,
    input logic io_m,
    input logic ready,
    input logic hold,
    input logic hlda,
    input logic done
);
    p_ale_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && a_hi_oe));
    p_ale_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);
    p_io_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_hi_oe && !ale) |-> $stable(io_m));
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));
    p_release_t3_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rd_n && wr_n));
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !ready) |=> !rd_n);
    p_wait_hold_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !ready) |=> !wr_n);
    p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_hold_float_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!ad_oe && !a_hi_oe && !ctl_oe && rd_n && wr_n && !ale));
    p_hlda_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hlda && !hold) |=> !hlda);
endmodule

bind mbus_cycle_ctrl mbus_cycle_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .ad_oe(ad_oe), .a_hi_oe(a_hi_oe),
    .ctl_oe(ctl_oe), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .ready(ready),
    .hold(hold), .hlda(hlda), .done(done)
);

// File: tb/tb_mbus_cycle_ctrl.sv
module tb_mbus_cycle_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic        req_ready;
    logic        ready = 1'b1;
    logic        hold = 1'b0;
    logic        hlda;
    logic [7:0]  ad_in = '0;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  a_hi;
    logic        a_hi_oe;
    logic        ale;
    logic        rd_n;
    logic        wr_n;
    logic        io_m;
    logic        ctl_oe;
    logic        reset_out;
    logic [7:0]  rd_data;
    logic        done;

    always #10 clk = ~clk;

    mbus_cycle_ctrl dut (.*);

    typedef struct {
        logic [15:0] addr;
        logic [7:0]  data;
        logic        write;
        logic        io;
        int          waits;
    } exp_t;

    exp_t        exp_q[$];
    logic [7:0]  wmem [logic [16:0]];
    int          n_tests = 0;
    int          n_fail = 0;
    int          wait_left = 0;
    int          strobe_cnt = 0;
    logic [7:0]  lat_lo = '0;
    logic [7:0]  lat_hi = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(input logic [15:0] a, input logic io);
        if (wmem.exists({io, a})) return wmem[{io, a}];
        return a[7:0] ^ a[15:8] ^ (io ? 8'hA5 : 8'h00);
    endfunction

    // Slave model: demux latch, ready generation, read data drive
    always @(negedge clk) begin
        if (ale) begin
            lat_lo = ad_out;
            lat_hi = a_hi;
            strobe_cnt = 0;
        end
        if (!rd_n || !wr_n) begin
            strobe_cnt++;
            if (wait_left > 0) begin
                ready = 1'b0;
                wait_left--;
            end else begin
                ready = 1'b1;
            end
        end else begin
            ready = 1'b1;
        end
        ad_in = !rd_n ? model_rd({lat_hi, lat_lo}, io_m) : 8'h00;
        if (!rd_n) chk(!ad_oe, "R6", "shared lines driven during read", ad_oe, 0);
        if (!wr_n) chk(ad_oe && ad_out == exp_q[0].data, "R5", "write data in strobe",
                       ad_out, exp_q[0].data);
    end

    // Monitor: pop expected item at end of each cycle
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R6", "done without request", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({lat_hi, lat_lo} == e.addr, "R1", "latched address", {lat_hi, lat_lo}, e.addr);
                chk(io_m == e.io, "R2", "io_m status", io_m, e.io);
                chk(rd_n && wr_n, "R3", "strobes released in T3", {rd_n, wr_n}, 2'b11);
                chk(strobe_cnt == e.waits + 1, "R4", "strobe length", strobe_cnt, e.waits + 1);
                chk(hlda == 1'b0, "R7", "no grant inside cycle", hlda, 0);
                if (e.write)
                    chk(ad_oe && ad_out == e.data, "R5", "write data in T3", ad_out, e.data);
                else
                    chk(rd_data == e.data, "R6", "read data", rd_data, e.data);
            end
        end
    end

    task automatic issue(input logic [15:0] a, input logic [7:0] d, input logic w,
                         input logic io, input int waits);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        e.addr = a; e.write = w; e.io = io; e.waits = waits;
        e.data = w ? d : model_rd(a, io);
        if (w) wmem[{io, a}] = d;
        exp_q.push_back(e);
        wait_left = waits;
        req_addr = a; req_wdata = d; req_write = w; req_io = io;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(ale == 1'b1, "R1", "ale in T1", ale, 1);
        chk(ad_out == a[7:0] && ad_oe, "R1", "low address on shared lines", ad_out, a[7:0]);
        chk(a_hi == a[15:8] && a_hi_oe, "R1", "upper address", a_hi, a[15:8]);
    endtask

    task automatic finish_cycle();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic do_cycle(input logic [15:0] a, input logic [7:0] d, input logic w,
                            input logic io, input int waits);
        issue(a, d, w, io, waits);
        finish_cycle();
    endtask

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R9: reset state
        #5;
        chk(!ad_oe && !a_hi_oe && !ctl_oe, "R9", "enables in reset", {ad_oe, a_hi_oe, ctl_oe}, 0);
        chk(reset_out == 1'b1, "R9", "reset_out in reset", reset_out, 1);
        chk(rd_n && wr_n && !hlda, "R9", "strobes in reset", {rd_n, wr_n, hlda}, 3'b110);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1 chk(reset_out == 1'b1, "R9", "reset_out before first edge", reset_out, 1);
        @(negedge clk);
        chk(reset_out == 1'b0, "R9", "reset_out after first edge", reset_out, 0);
        chk(req_ready == 1'b1, "R10", "ready in idle", req_ready, 1);

        do_cycle(16'h1234, 8'h5A, 1'b1, 1'b0, 0);   // memory write
        do_cycle(16'h1234, 8'h00, 1'b0, 1'b0, 0);   // memory read back
        do_cycle(16'h0040, 8'h00, 1'b0, 1'b1, 2);   // I/O read, 2 waits
        do_cycle(16'h00C3, 8'h3C, 1'b1, 1'b1, 3);   // I/O write, 3 waits
        do_cycle(16'hBEEF, 8'h00, 1'b0, 1'b0, 1);   // memory read, 1 wait
        do_cycle(16'h00C3, 8'h00, 1'b0, 1'b0, 0);   // same address, memory space
        do_cycle(16'h00C3, 8'h00, 1'b0, 1'b1, 0);   // I/O space keeps written byte

        // R7: hold raised during a read is granted only after it completes
        issue(16'h8001, 8'h00, 1'b0, 1'b0, 2);
        hold = 1'b1;
        @(negedge clk);
        chk(hlda == 1'b0, "R7", "no grant mid-cycle", hlda, 0);
        finish_cycle();
        repeat (2) @(negedge clk);
        chk(hlda == 1'b1, "R7", "grant after cycle", hlda, 1);
        chk(!ad_oe && !a_hi_oe && !ctl_oe, "R7", "bus floats", {ad_oe, a_hi_oe, ctl_oe}, 0);
        // R10: request during grant is held off
        req_valid = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!req_ready && !ale, "R10", "request ignored in hold", {req_ready, ale}, 0);
        end
        req_valid = 1'b0;
        @(negedge clk);
        hold = 1'b0;
        #1 chk(hlda == 1'b1, "R8", "hlda before release edge", hlda, 1);
        @(negedge clk);
        chk(hlda == 1'b0, "R8", "hlda one clock after release", hlda, 0);
        chk(req_ready == 1'b1, "R10", "ready after release", req_ready, 1);

        // Back-to-back after hold
        do_cycle(16'hFF00, 8'hC7, 1'b1, 1'b0, 1);
        do_cycle(16'hFF00, 8'h00, 1'b0, 1'b0, 3);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule